// File: doc/BRIEF.md
# Privilege Policy Runtime Monitor

This block is a synthesizable runtime checker that sits beside a pipelined 32-bit processor with two privilege levels, user and supervisor. It observes only architectural signals: the current mode, exception entry and return, the causes behind an exception, special-register writes with their group index, instruction fetches and debug-register accesses. It takes no part in the processor's operation and drives nothing back into it.

Each cycle the monitor evaluates five privilege rules. A rule broken in a given cycle sets its own fail bit at the next clock edge. That bit then stays set until reset. A single alarm output is the OR of all fail bits. The rules depend only on architectural meaning, so the monitor can be attached to any implementation that exposes these signals. Its per-cycle verdict is meant to match an equivalent simulation-only assertion written over the same signals.

Top module: `priv_policy_monitor`

## Requirements
- R1: A cycle with `spr_wr` high, `spr_group` equal to zero and `mode_sup` low sets `rule_fail[0]` at the next edge. A write to a non-zero group, or any write while `mode_sup` is high, leaves it clear.
- R2: If `mode_sup` was low in one cycle and is high in the next, and `exc_enter` is low in that next cycle, `rule_fail[1]` is set at the following edge. The first cycle after `rst_n` rises is exempt, and so is a rise that coincides with `exc_enter`.
- R3: A cycle with `exc_enter` high and every bit of `exc_cause` low sets `rule_fail[2]` at the next edge. With any cause bit high there is no failure.
- R4: A cycle with `fetch_valid` high, `fetch_addr` in the range [VEC_BASE, VEC_BASE+VEC_SIZE) (defaults 0x0 and 0x2000), `mode_sup` low and no exception in progress sets `rule_fail[3]`. An exception is in progress from the cycle in which `exc_enter` is high up to and including the cycle in which `exc_return` is high. Fetches outside the range, or with `fetch_valid` low, have no effect.
- R5: A cycle with `dbg_access` high and `mode_sup` low sets `rule_fail[4]` at the next edge. An access in supervisor mode has no effect.
- R6: `rst_n` is a synchronous active-low reset. It clears every fail bit. Once a fail bit is set, it remains set until the next reset.
- R7: `alarm` is high in exactly those cycles in which at least one bit of `rule_fail` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sup | input | 1 | Current privilege mode, 1 = supervisor |
| exc_enter | input | 1 | Exception-entry strobe |
| exc_cause | input | NCAUSE (4) | Exception-cause source lines |
| exc_return | input | 1 | Return-from-exception strobe |
| spr_wr | input | 1 | Special-register write strobe |
| spr_group | input | GW (5) | Group index of the written special register |
| fetch_valid | input | 1 | Instruction fetch valid |
| fetch_addr | input | AW (32) | Instruction fetch address |
| dbg_access | input | 1 | Debug value/control register access strobe |
| rule_fail | output | 5 | Sticky per-rule fail bits |
| alarm | output | 1 | OR of all fail bits |

## Verification
The assertions assume that every input carries a defined value in each cycle once reset is released, and that the mode input is a clean level that changes only at clock edges. The bench drives every input at the falling edge, always with explicit values, and holds all strobes low unless a step asserts them. The bench pairs `exc_enter` and `exc_return` as a processor would, and never asserts both in the same cycle. It exercises each rule both with the context that permits the behaviour and without it.

// File: rtl/priv_mon_pkg.sv
// Shared constants and types for the privilege policy monitor.
package priv_mon_pkg;
    localparam int NRULES     = 5;
    localparam int RULE_SPR   = 0;  // group-0 special-register write outside supervisor
    localparam int RULE_ESC   = 1;  // user-to-supervisor change without exception entry
    localparam int RULE_CAUSE = 2;  // exception entry with no cause
    localparam int RULE_VEC   = 3;  // vector-region fetch outside permitted context
    localparam int RULE_DBG   = 4;  // debug register access outside supervisor

    typedef logic [NRULES-1:0] rule_vec_t;
endpackage

// File: rtl/priv_exc_tracker.sv
// Tracks the exception window and the previous-cycle mode.
// Assumes exc_enter and exc_return are single-cycle strobes; entry wins if both occur together.
module priv_exc_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sup,
    input  logic exc_enter,
    input  logic exc_return,
    output logic exc_active,
    output logic was_user
);
    logic in_exc_q;
    logic armed_q;
    logic prev_sup_q;

    // Registers the exception window, the post-reset arming flag and the last mode.
    always_ff @(posedge clk) begin
        prev_sup_q <= mode_sup;
        if (!rst_n) begin
            in_exc_q <= 1'b0;
            armed_q  <= 1'b0;
        end else begin
            in_exc_q <= exc_enter | (in_exc_q & ~exc_return);
            armed_q  <= 1'b1;
        end
    end

    // The window includes both the entry cycle and the return cycle.
    always_comb exc_active = in_exc_q | exc_enter;

    // Previous mode counts only after the first cycle following reset.
    always_comb was_user = armed_q & ~prev_sup_q;
endmodule

// File: rtl/priv_rule_eval.sv
// Combinational evaluation of all privilege rules for the current cycle.
// Assumes inputs are stable around the sampling edge; produces one violation bit per rule.
module priv_rule_eval
    import priv_mon_pkg::*;
#(
    parameter int             AW       = 32,
    parameter int             GW       = 5,
    parameter int             NCAUSE   = 4,
    parameter logic [AW-1:0]  VEC_BASE = '0,
    parameter logic [AW-1:0]  VEC_SIZE = AW'('h2000)
) (
    input  logic              mode_sup,
    input  logic              exc_enter,
    input  logic [NCAUSE-1:0] exc_cause,
    input  logic              exc_active,
    input  logic              was_user,
    input  logic              spr_wr,
    input  logic [GW-1:0]     spr_group,
    input  logic              fetch_valid,
    input  logic [AW-1:0]     fetch_addr,
    input  logic              dbg_access,
    output rule_vec_t         viol
);
    logic [AW-1:0] vec_offset;
    logic          in_vec;

    // Offset comparison keeps the range test free of a lower-bound compare.
    always_comb begin
        vec_offset = fetch_addr - VEC_BASE;
        in_vec     = vec_offset < VEC_SIZE;
    end

    // One violation term per rule.
    always_comb begin
        viol             = '0;
        viol[RULE_SPR]   = spr_wr & (spr_group == '0) & ~mode_sup;
        viol[RULE_ESC]   = was_user & mode_sup & ~exc_enter;
        viol[RULE_CAUSE] = exc_enter & ~(|exc_cause);
        viol[RULE_VEC]   = fetch_valid & in_vec & ~mode_sup & ~exc_active;
        viol[RULE_DBG]   = dbg_access & ~mode_sup;
    end
endmodule

// File: rtl/priv_sticky_flags.sv
// One sticky flag per rule, cleared only by synchronous reset.
module priv_sticky_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_in,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Latch the violation for rule i until reset.
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else if (set_in[i]) flags[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/priv_policy_monitor.sv
// Top of the privilege policy monitor: tracker, rule evaluation and sticky flags.
// Assumes only architectural signals of the observed processor; drives nothing back.
module priv_policy_monitor
    import priv_mon_pkg::*;
#(
    parameter int             AW       = 32,
    parameter int             GW       = 5,
    parameter int             NCAUSE   = 4,
    parameter logic [AW-1:0]  VEC_BASE = '0,
    parameter logic [AW-1:0]  VEC_SIZE = AW'('h2000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sup,
    input  logic              exc_enter,
    input  logic [NCAUSE-1:0] exc_cause,
    input  logic              exc_return,
    input  logic              spr_wr,
    input  logic [GW-1:0]     spr_group,
    input  logic              fetch_valid,
    input  logic [AW-1:0]     fetch_addr,
    input  logic              dbg_access,
    output logic [NRULES-1:0] rule_fail,
    output logic              alarm
);
    logic      exc_active;
    logic      was_user;
    rule_vec_t viol;

    priv_exc_tracker u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sup   (mode_sup),
        .exc_enter  (exc_enter),
        .exc_return (exc_return),
        .exc_active (exc_active),
        .was_user   (was_user)
    );

    priv_rule_eval #(
        .AW(AW), .GW(GW), .NCAUSE(NCAUSE), .VEC_BASE(VEC_BASE), .VEC_SIZE(VEC_SIZE)
    ) u_eval (
        .mode_sup    (mode_sup),
        .exc_enter   (exc_enter),
        .exc_cause   (exc_cause),
        .exc_active  (exc_active),
        .was_user    (was_user),
        .spr_wr      (spr_wr),
        .spr_group   (spr_group),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .dbg_access  (dbg_access),
        .viol        (viol)
    );

    priv_sticky_flags #(.N(NRULES)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_in (viol),
        .flags  (rule_fail)
    );

    // Aggregate alarm.
    always_comb alarm = |rule_fail;
endmodule

// File: rtl/priv_policy_monitor_sva.sv
// Checker bound to the monitor: relates input behaviour to the fail outputs over time.
module priv_policy_monitor_sva #(
    parameter int GW     = 5,
    parameter int NCAUSE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_sup,
    input logic              exc_enter,
    input logic [NCAUSE-1:0] exc_cause,
    input logic              spr_wr,
    input logic [GW-1:0]     spr_group,
    input logic              fetch_valid,
    input logic              dbg_access,
    input logic [4:0]        rule_fail,
    input logic              alarm
);
    assert_spr_user_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_wr && spr_group == '0 && !mode_sup) |=> rule_fail[0]);

    assert_escalation_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rule_fail[1]) |-> $past(mode_sup && !exc_enter));

    assert_no_cause_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter && exc_cause == '0) |=> rule_fail[2]);

    assert_vector_fetch_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rule_fail[3]) |-> $past(fetch_valid && !mode_sup));

    assert_debug_user_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_access && !mode_sup) |=> rule_fail[4]);

    assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rule_fail != '0) |=> ((rule_fail & $past(rule_fail)) == $past(rule_fail)));

    assert_alarm_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> (rule_fail != '0));
endmodule

bind priv_policy_monitor priv_policy_monitor_sva #(.GW(GW), .NCAUSE(NCAUSE)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sup    (mode_sup),
    .exc_enter   (exc_enter),
    .exc_cause   (exc_cause),
    .spr_wr      (spr_wr),
    .spr_group   (spr_group),
    .fetch_valid (fetch_valid),
    .dbg_access  (dbg_access),
    .rule_fail   (rule_fail),
    .alarm       (alarm)
);

// File: tb/priv_policy_monitor_bench.sv
`timescale 1ns/1ps
module priv_policy_monitor_bench;
    localparam int AW = 32;
    localparam int GW = 5;
    localparam int NC = 4;
    localparam logic [AW-1:0] VSIZE = 32'h2000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_sup;
    logic          exc_enter;
    logic [NC-1:0] exc_cause;
    logic          exc_return;
    logic          spr_wr;
    logic [GW-1:0] spr_group;
    logic          fetch_valid;
    logic [AW-1:0] fetch_addr;
    logic          dbg_access;
    logic [4:0]    rule_fail;
    logic          alarm;

    typedef struct { logic [4:0] exp; string tag; } item_t;
    item_t q[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state built from the requirements.
    bit         m_exc   = 0;
    bit         m_armed = 0;
    bit         m_prev  = 0;
    logic [4:0] m_fail  = '0;

    always #4 clk = ~clk;

    priv_policy_monitor u_priv_policy_monitor (
        .clk(clk), .rst_n(rst_n), .mode_sup(mode_sup), .exc_enter(exc_enter),
        .exc_cause(exc_cause), .exc_return(exc_return), .spr_wr(spr_wr),
        .spr_group(spr_group), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .dbg_access(dbg_access), .rule_fail(rule_fail), .alarm(alarm)
    );

    // Driver: applies one cycle of stimulus and queues the expected flags.
    task automatic step(input bit rst, input bit md, input bit ee, input logic [NC-1:0] cs,
                        input bit er, input bit sw, input logic [GW-1:0] grp, input bit fv,
                        input logic [AW-1:0] fa, input bit dbg, input string tag);
        logic [4:0] v;
        item_t it;
        @(negedge clk);
        rst_n = ~rst; mode_sup = md; exc_enter = ee; exc_cause = cs; exc_return = er;
        spr_wr = sw; spr_group = grp; fetch_valid = fv; fetch_addr = fa; dbg_access = dbg;
        v = '0;
        if (rst) begin
            m_fail = '0; m_exc = 0; m_armed = 0;
        end else begin
            v[0] = sw && grp == 0 && !md;
            v[1] = m_armed && !m_prev && md && !ee;
            v[2] = ee && cs == 0;
            v[3] = fv && fa < VSIZE && !md && !(m_exc || ee);
            v[4] = dbg && !md;
            m_fail = m_fail | v;
            m_exc = ee ? 1'b1 : (er ? 1'b0 : m_exc);
            m_armed = 1;
        end
        m_prev = md;
        it.exp = m_fail; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input bit md, input string tag);
        step(0, md, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: pops expected items after each rising edge and compares.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (rule_fail !== it.exp) begin
                    fails++;
                    $display("FAIL %s: rule_fail actual=%b expected=%b", it.tag, rule_fail, it.exp);
                end
                checks++;
                if (alarm !== (|it.exp)) begin
                    fails++;
                    $display("FAIL R7 (%s): alarm actual=%b expected=%b", it.tag, alarm, |it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 reset");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 reset");
        // Start-up: supervisor right after reset is exempt.
        idle(1, "R2 startup exempt");
        step(0, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R1 supervisor group0 write");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R5 supervisor debug access");
        step(0, 1, 0, 0, 0, 0, 0, 1, 32'h100, 0, "R4 supervisor vector fetch");
        idle(0, "R2 drop to user");
        step(0, 0, 0, 0, 0, 1, 5'd3, 0, 0, 0, "R1 user other group");
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'h2000, 0, "R4 fetch just outside");
        step(0, 0, 0, 0, 0, 0, 0, 0, 32'h10, 0, "R4 fetch not valid");
        step(0, 1, 1, 4'b0100, 0, 0, 0, 1, 32'h100, 0, "R2 R3 R4 entry with cause");
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'h1FFC, 0, "R4 user fetch inside exception");
        step(0, 0, 0, 0, 1, 0, 0, 1, 32'h200, 0, "R4 fetch in return cycle");
        step(0, 0, 0, 0, 0, 0, 0, 1, 32'h100, 0, "R4 user vector fetch fails");
        idle(0, "R6 sticky");
        idle(0, "R6 sticky");
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R1 user group0 write fails");
        step(0, 0, 1, 4'b0000, 0, 0, 0, 0, 0, 0, "R3 entry without cause");
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R3 return");
        idle(1, "R2 escalation without entry");
        idle(0, "R2 back to user");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R5 user debug access fails");
        idle(0, "R6 all sticky");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 reset clears");
        idle(0, "R6 after reset");
        idle(0, "R2 user");
        idle(1, "R2 late escalation");
        idle(1, "R7 single bit alarm");
        repeat (4) @(posedge clk);
        #3;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule